// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block is the controller-side serial engine that loads a 16-bit voltage-output DAC over a three-wire link made of a frame strobe, a serial clock and a data line. A command arrives through a valid/ready handshake. It carries a 16-bit output code and a 2-bit output-stage mode, or a request for the receiver's software reset. The block turns the command into a 24-bit frame and shifts it out with the most significant bit first. It then releases the frame strobe, holds it high for a guard interval, and pulses `done_o`.

All timing comes from the system clock. Three parameters set, in system clock cycles, the lead time from the strobe falling to the first serial clock rise, the serial clock half-period, and the strobe-high guard interval. The serial clock idles low. The data line changes only when the serial clock rises, so the receiver can capture each bit on the falling edge. Built-in checks compare the resulting waveform against nanosecond minimums, using the system clock period given as a parameter.

Top module: `dac_frame_tx`

## Requirements
- R1: `sclk_o` is low whenever `sync_no` is high. `sdo_o` changes only in the cycle where `sclk_o` rises or `sync_no` rises, so it is stable across every falling `sclk_o` edge.
- R2: Each frame has exactly 24 falling `sclk_o` edges while `sync_no` is low. Frame bit 23 is on `sdo_o` at the first falling edge and bit 0 at the last.
- R3: For a command with `cmd_reset_i` low, the frame carries `cmd_code_i` in bits 15:0 and `cmd_mode_i` in bits 17:16, with bits 23:18 zero.
- R4: For a command with `cmd_reset_i` high, every frame bit is one, whatever `cmd_mode_i` and `cmd_code_i` hold.
- R5: Inside a frame, each `sclk_o` high phase and each low phase lasts HALF_CYC system cycles. High time must be at least 5 ns, low time at least 3 ns, and the period between falling edges at least 33 ns.
- R6: `sync_no` falls LEAD_CYC cycles before the first `sclk_o` rise, which gives at least 10 ns of setup before the first falling edge.
- R7: After a frame, `sync_no` stays high for GAP_CYC cycles before `cmd_ready_o` returns, and no frame starts less than 33 ns after `sync_no` rises.
- R8: A command is taken only in a cycle where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` stays low from acceptance until the guard interval ends. Command inputs presented while busy have no effect on the frame in flight and start no extra frame.
- R9: `done_o` is a one-cycle pulse that comes one cycle after `sync_no` rises, once per frame.
- R10: While `rst_ni` is low and after it is released, `sync_no` is high, `sclk_o` low, `sdo_o` low, `done_o` low and `cmd_ready_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle and able to take a command |
| cmd_reset_i | input | 1 | Command is a receiver reset (all-ones frame) |
| cmd_mode_i | input | 2 | Output-stage mode placed in frame bits 17:16 |
| cmd_code_i | input | 16 | DAC code placed in frame bits 15:0 |
| sync_no | output | 1 | Frame strobe, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data, MSB first |
| done_o | output | 1 | One-cycle pulse after the frame closes |

## Verification
Assertions check on every cycle the properties of the line signals. These are the serial clock idling low, data changing only on the rising edge, the high, low and period minimums in nanoseconds, the strobe setup and guard minimums, the count of 24 falling edges, ready being low during a frame, and the placement of the done pulse. Only the bench scenarios show what the frame contains. The bench decodes the line and compares the result with the command for every mode and for walking-one, complementary and extreme codes, and it checks that reset frames are all ones. The bench also shows the exact phase lengths in cycles, and that a command held on the inputs during a busy frame neither alters that frame nor starts a second one.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  localparam int FRAME_W = 24;
  localparam int MODE_W  = 2;
  localparam int CODE_W  = 16;
  localparam int PAD_W   = FRAME_W - MODE_W - CODE_W;
  localparam int MON_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HIGH = 3'd2,
    ST_LOW  = 3'd3,
    ST_GAP  = 3'd4
  } tx_state_e;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              rst_req,
    input logic [MODE_W-1:0] mode,
    input logic [CODE_W-1:0] code
  );
    if (rst_req) return '1;
    return {{PAD_W{1'b0}}, mode, code};
  endfunction

  function automatic logic [MON_W-1:0] sat_inc(input logic [MON_W-1:0] v);
    return (&v) ? v : v + MON_W'(1);
  endfunction
endpackage

// File: rtl/dac_tx_timer.sv
module dac_tx_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last_o = (cnt_q == limit_i - CNT_W'(1));
endmodule

// File: rtl/dac_tx_shifter.sv
module dac_tx_shifter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/dac_tx_seq.sv
module dac_tx_seq
  import dac_tx_pkg::*;
#(
  parameter int FW       = 24,
  parameter int LEAD_CYC = 1,
  parameter int HALF_CYC = 2,
  parameter int GAP_CYC  = 3,
  parameter int CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             last_i,
  input  logic             msb_i,
  output logic [CNT_W-1:0] limit_o,
  output logic             restart_o,
  output logic             shift_o,
  output logic             ready_o,
  output logic             sync_no,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             done_o
);
  localparam int IDX_W = $clog2(FW);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FW - 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             end_q;
  logic             final_bit;

  assign final_bit = (state_q == ST_LOW) && last_i && (idx_q == LAST_IDX);
  assign restart_o = accept_i | last_i;
  assign ready_o   = (state_q == ST_IDLE);
  assign shift_o   = last_i && ((state_q == ST_LEAD) ||
                                ((state_q == ST_LOW) && (idx_q != LAST_IDX)));

  always_comb begin
    case (state_q)
      ST_LEAD: limit_o = CNT_W'(LEAD_CYC);
      ST_GAP:  limit_o = CNT_W'(GAP_CYC);
      default: limit_o = CNT_W'(HALF_CYC);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      end_q   <= 1'b0;
      done_o  <= 1'b0;
      sync_no <= 1'b1;
      sclk_o  <= 1'b0;
      sdo_o   <= 1'b0;
    end else begin
      end_q  <= final_bit;
      done_o <= end_q;
      case (state_q)
        ST_IDLE: if (accept_i) begin
          state_q <= ST_LEAD;
          sync_no <= 1'b0;
          idx_q   <= '0;
        end
        ST_LEAD: if (last_i) begin
          state_q <= ST_HIGH;
          sclk_o  <= 1'b1;
          sdo_o   <= msb_i;
        end
        ST_HIGH: if (last_i) begin
          state_q <= ST_LOW;
          sclk_o  <= 1'b0;
        end
        ST_LOW: if (last_i) begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_GAP;
            sync_no <= 1'b1;
            sdo_o   <= 1'b0;
          end else begin
            state_q <= ST_HIGH;
            sclk_o  <= 1'b1;
            sdo_o   <= msb_i;
            idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_GAP: if (last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: done trails frame close by one cycle
  assert_done_after_close_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_no) |=> done_o);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_tx_pkg::*;
#(
  parameter int LEAD_CYC     = 1,
  parameter int HALF_CYC     = 2,
  parameter int GAP_CYC      = 3,
  parameter int CLK_NS       = 10,
  parameter int HI_MIN_NS    = 5,
  parameter int LO_MIN_NS    = 3,
  parameter int PER_MIN_NS   = 33,
  parameter int SETUP_MIN_NS = 10,
  parameter int GAP_MIN_NS   = 33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_reset_i,
  input  logic [MODE_W-1:0] cmd_mode_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  output logic              sync_no,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              done_o
);
  localparam int MAX_A   = (LEAD_CYC > HALF_CYC) ? LEAD_CYC : HALF_CYC;
  localparam int MAX_CYC = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int FC_W    = $clog2(FRAME_W + 1) + 1;

  logic             accept, last, msb, restart, shift;
  logic [CNT_W-1:0] limit;

  assign accept = cmd_valid_i & cmd_ready_o;

  dac_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .restart_i(restart), .limit_i(limit), .last_o(last)
  );

  dac_tx_shifter #(.W(FRAME_W)) u_shift (
    .clk_i, .rst_ni, .load_i(accept),
    .data_i(build_frame(cmd_reset_i, cmd_mode_i, cmd_code_i)),
    .shift_i(shift), .msb_o(msb)
  );

  dac_tx_seq #(
    .FW(FRAME_W), .LEAD_CYC(LEAD_CYC), .HALF_CYC(HALF_CYC),
    .GAP_CYC(GAP_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni, .accept_i(accept), .last_i(last), .msb_i(msb),
    .limit_o(limit), .restart_o(restart), .shift_o(shift),
    .ready_o(cmd_ready_o), .sync_no, .sclk_o, .sdo_o, .done_o
  );

  // Line timing monitors for the checks below
  logic             sclk_q, seen_q;
  logic [MON_W-1:0] hi_run, lo_run, per_run, lead_run, gap_run;
  logic [FC_W-1:0]  fall_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      seen_q   <= 1'b0;
      hi_run   <= '0;
      lo_run   <= '0;
      per_run  <= '0;
      lead_run <= '0;
      gap_run  <= '0;
      fall_cnt <= '0;
    end else begin
      sclk_q   <= sclk_o;
      seen_q   <= seen_q | ~sync_no;
      hi_run   <= sclk_o ? sat_inc(hi_run) : '0;
      lo_run   <= sclk_o ? '0 : sat_inc(lo_run);
      per_run  <= (sclk_q & ~sclk_o) ? MON_W'(1) : sat_inc(per_run);
      lead_run <= sync_no ? '0 : sat_inc(lead_run);
      gap_run  <= sync_no ? sat_inc(gap_run) : '0;
      fall_cnt <= sync_no ? '0 : fall_cnt + FC_W'(sclk_q & ~sclk_o);
    end
  end

  assert_sclk_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_no |-> !sclk_o);
  assert_sdo_moves_on_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($rose(sclk_o) || $rose(sync_no)));
  assert_frame_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_no) |-> (fall_cnt == FC_W'(FRAME_W)));
  assert_sclk_high_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (int'(hi_run) * CLK_NS >= HI_MIN_NS));
  assert_sclk_low_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (int'(lo_run) * CLK_NS >= LO_MIN_NS));
  assert_sclk_period_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && fall_cnt != '0) |-> (int'(per_run) * CLK_NS >= PER_MIN_NS));
  assert_sync_setup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && fall_cnt == '0) |-> (int'(lead_run) * CLK_NS >= SETUP_MIN_NS));
  assert_sync_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sync_no) && seen_q) |-> (int'(gap_run) * CLK_NS >= GAP_MIN_NS));
  assert_busy_not_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_no |-> !cmd_ready_o);
endmodule

// File: tb/dac_frame_tx_tb.sv
module dac_frame_tx_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;
  localparam int LEAD = 1;
  localparam int HALF = 2;
  localparam int GAP  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, rq = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] code = '0;
  logic ready, sync_n, sclk, sdo, done;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_frame_tx #(.LEAD_CYC(LEAD), .HALF_CYC(HALF), .GAP_CYC(GAP), .CLK_NS(CLK_PERIOD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_reset_i(rq), .cmd_mode_i(mode), .cmd_code_i(code),
    .sync_no(sync_n), .sclk_o(sclk), .sdo_o(sdo), .done_o(done)
  );

  // Line decoder and timing monitor
  logic p_sclk = 1'b0, p_sync = 1'b1, p_sdo = 1'b0;
  logic [23:0] rx = '0, last_frame = '0;
  int rx_bits = 0, last_bits = 0, run = 0, lead_meas = 0;
  int frames = 0, since_rise = 0, done_lag = 0, done_cnt = 0, gap_meas = 0;
  bit first_rise = 0, tim_err = 0, overlap_err = 0, r1_err = 0, gap_closed = 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = 1'b0; p_sync = 1'b1; p_sdo = 1'b0;
    end else begin
      if (!sync_n && ready) overlap_err = 1;
      if (sync_n && sclk) r1_err = 1;
      if (sdo !== p_sdo && !(sclk && !p_sclk) && !(sync_n && !p_sync)) r1_err = 1;
      if (p_sync && !sync_n) begin
        rx = '0; rx_bits = 0; run = 0; first_rise = 1;
      end
      if (!sync_n) begin
        if (sclk != p_sclk) begin
          if (first_rise) begin lead_meas = run; first_rise = 0; end
          else if (run != HALF) tim_err = 1;
          run = 1;
        end else run++;
        if (p_sclk && !sclk) begin rx = {rx[22:0], sdo}; rx_bits++; end
      end
      if (!p_sync && sync_n) begin
        frames++; last_frame = rx; last_bits = rx_bits;
        since_rise = 0; done_lag = -1; done_cnt = 0; gap_meas = 0; gap_closed = 0;
      end else since_rise++;
      if (done) begin done_cnt++; done_lag = since_rise; end
      if (sync_n && !gap_closed) begin
        if (ready) gap_closed = 1; else gap_meas++;
      end
      p_sclk = sclk; p_sync = sync_n; p_sdo = sdo;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input bit r, input logic [1:0] m, input logic [15:0] c, input int hold);
    int f0;
    logic [23:0] exp;
    f0 = frames;
    @(negedge clk); #1;
    while (!ready) begin @(negedge clk); #1; end
    valid = 1'b1; rq = r; mode = m; code = c;
    @(negedge clk); #1;
    // busy-time stimulus must not reach the line (R8)
    rq = ~r; mode = ~m; code = ~c;
    for (int i = 0; i < hold; i++) begin @(negedge clk); #1; end
    valid = 1'b0;
    @(negedge clk); #1;
    while (!(frames == f0 + 1 && gap_closed)) begin @(negedge clk); #1; end
    exp = r ? 24'hFFFFFF : {6'b0, m, c};
    chk(last_frame == exp, r ? "R4 reset frame" : "R3 frame content", last_frame, exp);
    chk(last_bits == 24, "R2 falling edges", last_bits, 24);
    chk(!tim_err, "R5 half-period", tim_err, 0);
    chk(lead_meas == LEAD, "R6 lead cycles", lead_meas, LEAD);
    chk(gap_meas == GAP, "R7 guard cycles", gap_meas, GAP);
    chk(done_lag == 1 && done_cnt == 1, "R9 done pulse", done_lag, 1);
    chk(!overlap_err, "R8 ready during frame", overlap_err, 0);
    chk(!r1_err, "R1 sclk idle / sdo edge", r1_err, 0);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sync_n === 1'b1 && sclk === 1'b0 && sdo === 1'b0 && done === 1'b0 && ready === 1'b1,
        "R10 in reset", {sync_n, sclk, sdo, done, ready}, 5'b10001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sync_n === 1'b1 && sclk === 1'b0 && sdo === 1'b0 && done === 1'b0 && ready === 1'b1,
        "R10 after release", {sync_n, sclk, sdo, done, ready}, 5'b10001);

    // R3 sweep: every mode, walking ones, complements, extremes
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 18; k++) begin
        logic [15:0] c;
        c = (k < 16) ? (16'h1 << k) : ((k == 16) ? 16'h0000 : 16'hFFFF);
        if (m[0]) c = ~c;
        send(1'b0, 2'(m), c, 0);
      end
    end

    // R4: reset frame ignores mode and code
    send(1'b1, 2'b00, 16'h0000, 0);
    send(1'b1, 2'b10, 16'h5A3C, 0);
    send(1'b0, 2'b01, 16'hA5C3, 0);

    // R8: command held on the inputs while busy
    begin
      int f1;
      f1 = frames;
      send(1'b0, 2'b10, 16'h1234, 40);
      repeat (8) @(negedge clk);
      #1;
      chk(frames == f1 + 1 && sync_n === 1'b1, "R8 no extra frame", frames - f1, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule